// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous EDO DRAM interface. It watches the four active-low strobes (row strobe, column strobe, write enable, output enable) with a fast system clock. It first passes them through a synchronizer and then finds their edges. From the order in which those edges arrive, the decoder names the memory cycle in progress. It also produces the control events that a storage array behind it needs: a row-latch pulse with the captured row, a column-latch pulse with the captured column, a write pulse with the captured data nibble, a refresh pulse from an internal refresh row counter, and the enable for the tri-state data outputs.

No command code is involved. The cycle type comes only from edge order. A column strobe that is already low when the row strobe falls starts a refresh and not an access. A write-enable that is low before the column strobe falls gives an early write. A write-enable that falls after the output has been turned on gives a read-modify-write. The address and data buses go through the same number of register stages as the strobes, so every capture matches the strobe sample that triggered it.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, and on any sample where the row and column strobes are both high, the cycle type is standby (bit 0), `dq_oe` is 0, and all latched registers and the refresh row read 0 after reset.
- R2: A row-strobe fall while the column strobe is high pulses `row_stb` once, loads `row_addr` from `addr`, and reports RAS-only refresh (bit 7) until a column-strobe fall.
- R3: A column-strobe fall while the row strobe is low pulses `col_stb`, loads `col_addr` from `addr`, and reports read (bit 1) when write-enable is high.
- R4: In a read, `dq_oe` rises only once the column strobe and output enable are both low with write-enable high (whichever falls later starts it), and it drops whenever output enable is high.
- R5: If write-enable is already low when the column strobe falls, the cycle is a write (bit 2). `wr_stb` pulses, `wr_data` takes `dq_in`, and `dq_oe` stays 0 for the rest of the cycle even if output enable falls.
- R6: If write-enable falls after the column strobe while the output was not driven, the cycle is a write (bit 2), and `wr_data` holds the `dq_in` value present at that write-enable fall.
- R7: A write-enable fall while the output is being driven gives read-modify-write (bit 3). It pulses `wr_stb` and turns `dq_oe` off.
- R8: Each column-strobe fall after the first, within one row-strobe low period, is a page access. It reports page read (bit 4) or page write (bit 5), latches a new column and keeps `row_addr`. While output enable is low, `dq_oe` stays on through the column strobe's high time.
- R9: A row-strobe fall with the column strobe held low after a read or write in the same cycle is a hidden refresh (bit 6). It keeps `dq_oe` as it was and pulses `ref_stb`.
- R10: A row-strobe fall with the column strobe low and no prior access is a CAS-before-RAS refresh (bit 8). `addr` is ignored, so `row_addr` is unchanged, `dq_oe` stays 0, and `ref_stb` pulses.
- R11: Each `ref_stb` pulse advances `ref_row` by one, modulo 2^REF_W (2048 by default), so that it wraps to 0.
- R12: `cyc_type` has exactly one bit set at all times.
- R13: A strobe change applied between clock edges shows up on the outputs at the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Data bus input side |
| cyc_type | output | 9 | One-hot cycle type (bit order in R1-R10) |
| row_stb | output | 1 | One-cycle row-latch pulse |
| col_stb | output | 1 | One-cycle column-latch pulse |
| row_addr | output | ADDR_W | Last latched row |
| col_addr | output | ADDR_W | Last latched column |
| wr_stb | output | 1 | One-cycle write pulse |
| wr_data | output | DATA_W | Data captured at the write point |
| dq_oe | output | 1 | Data output drive enable |
| ref_stb | output | 1 | One-cycle internal-counter refresh pulse |
| ref_row | output | REF_W | Refresh row counter |

## Verification
The main stimulus is a sequence of strobe patterns that differ only in edge order. Write-enable low before or after the column fall separates early write from late write, and a late write before or after output drive separates write from read-modify-write. A column strobe held low or released across a row-strobe toggle separates hidden refresh from a fresh cycle, and a column strobe low before the row fall, with or without a prior access, separates refresh from an access. Page patterns toggle only the column strobe to show that the row is kept and the EDO output is held. Directed tests add the exact three-edge latency, address and data capture values, the ignored address during refresh, and the refresh counter wrapping after 2048 refreshes.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    // Cycle classes; the numeric value is the bit index in the one-hot output.
    typedef enum logic [3:0] {
        CYC_STANDBY = 4'd0,
        CYC_READ    = 4'd1,
        CYC_WRITE   = 4'd2,
        CYC_RMW     = 4'd3,
        CYC_PAGE_RD = 4'd4,
        CYC_PAGE_WR = 4'd5,
        CYC_HIDDEN  = 4'd6,
        CYC_RAS_REF = 4'd7,
        CYC_CBR     = 4'd8
    } cyc_e;

    localparam int NUM_CYC = 9;
    localparam int NUM_STB = 4;

    // Strobe bundle, raw pin polarity (0 = asserted). Field order is the
    // packing order used when the pins are concatenated.
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
    parameter int   WIDTH   = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        for (int s = STAGES - 1; s > 0; s--) begin
            pipe_d[s] = pipe_q[s-1];
        end
        pipe_d[0] = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{{WIDTH{RST_VAL}}}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[TOP];

    initial begin
        assert (STAGES >= 2) else $error("dcd_sync needs at least two stages");
    end
endmodule

// File: rtl/dcd_edge.sv
module dcd_edge #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= {WIDTH{1'b1}};
        else        prev_q <= prev_d;
    end

    // A strobe asserts when it goes from high to low.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fall
        assign fall[i] = prev_q[i] & ~lvl[i];
    end
endmodule

// File: rtl/dcd_refcnt.sv
module dcd_refcnt #(
    parameter int REF_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [REF_W-1:0] cnt
);
    logic [REF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    assert_ref_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt_q == REF_W'($past(cnt_q) + 1'b1)));

    assert_ref_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           lvl,
    input  strobe_t           fall,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output cyc_e              kind,
    output logic              row_stb,
    output logic              col_stb,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              dq_oe,
    output logic              ref_stb
);
    typedef struct packed {
        cyc_e              kind;
        logic              seen_cas;
        logic              accessed;
        logic              drive;
        logic              row_stb;
        logic              col_stb;
        logic              wr_stb;
        logic              ref_stb;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [DATA_W-1:0] wdat;
    } st_t;

    st_t st_d, st_q;

    logic ras_lo, cas_lo, we_lo, oe_lo;
    logic in_refresh, in_read;

    always_comb begin
        ras_lo     = !lvl.ras;
        cas_lo     = !lvl.cas;
        we_lo      = !lvl.we;
        oe_lo      = !lvl.oe;
        in_refresh = (st_q.kind == CYC_CBR) || (st_q.kind == CYC_HIDDEN);
        in_read    = (st_q.kind == CYC_READ) || (st_q.kind == CYC_PAGE_RD);

        st_d         = st_q;
        st_d.row_stb = 1'b0;
        st_d.col_stb = 1'b0;
        st_d.wr_stb  = 1'b0;
        st_d.ref_stb = 1'b0;

        if (!ras_lo && !cas_lo) begin
            // Both strobes released: the cycle is over.
            st_d.kind     = CYC_STANDBY;
            st_d.seen_cas = 1'b0;
            st_d.accessed = 1'b0;
            st_d.drive    = 1'b0;
        end else begin
            if (fall.ras) begin
                if (cas_lo) begin
                    // Column strobe already low: refresh from the internal counter.
                    st_d.ref_stb = 1'b1;
                    if (st_q.accessed) begin
                        st_d.kind = CYC_HIDDEN;
                    end else begin
                        st_d.kind  = CYC_CBR;
                        st_d.drive = 1'b0;
                    end
                end else begin
                    st_d.row_stb  = 1'b1;
                    st_d.row      = addr_s;
                    st_d.kind     = CYC_RAS_REF;
                    st_d.seen_cas = 1'b0;
                    st_d.accessed = 1'b0;
                    st_d.drive    = 1'b0;
                end
            end else if (fall.cas && ras_lo && !in_refresh) begin
                st_d.col_stb  = 1'b1;
                st_d.col      = addr_s;
                st_d.seen_cas = 1'b1;
                if (we_lo) begin
                    st_d.kind     = st_q.seen_cas ? CYC_PAGE_WR : CYC_WRITE;
                    st_d.wr_stb   = 1'b1;
                    st_d.wdat     = din_s;
                    st_d.drive    = 1'b0;
                    st_d.accessed = 1'b1;
                end else begin
                    st_d.kind     = st_q.seen_cas ? CYC_PAGE_RD : CYC_READ;
                    st_d.drive    = oe_lo;
                    st_d.accessed = st_q.accessed | oe_lo;
                end
            end else if (fall.we && cas_lo && ras_lo && in_read) begin
                // Late write: either after the output was on, or a plain write.
                if (st_q.drive)                      st_d.kind = CYC_RMW;
                else if (st_q.kind == CYC_PAGE_RD)   st_d.kind = CYC_PAGE_WR;
                else                                 st_d.kind = CYC_WRITE;
                st_d.wr_stb   = 1'b1;
                st_d.wdat     = din_s;
                st_d.drive    = 1'b0;
                st_d.accessed = 1'b1;
            end else if (fall.oe && cas_lo && !we_lo && in_read) begin
                st_d.drive    = 1'b1;
                st_d.accessed = 1'b1;
            end

            if (!oe_lo) st_d.drive = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= CYC_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign kind     = st_q.kind;
    assign row_stb  = st_q.row_stb;
    assign col_stb  = st_q.col_stb;
    assign row_addr = st_q.row;
    assign col_addr = st_q.col;
    assign wr_stb   = st_q.wr_stb;
    assign wr_data  = st_q.wdat;
    assign dq_oe    = st_q.drive;
    assign ref_stb  = st_q.ref_stb;

    assert_standby_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CYC_STANDBY) |-> (!st_q.drive && !st_q.seen_cas));

    assert_row_stb_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row_stb |-> (st_q.kind == CYC_RAS_REF));

    assert_write_tristate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CYC_WRITE) |-> !st_q.drive);

    assert_rmw_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CYC_RMW) |-> !st_q.drive);

    assert_cbr_tristate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CYC_CBR) |-> !st_q.drive);

    assert_cbr_row_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.kind == CYC_CBR) && ($past(st_q.kind) == CYC_CBR)) |-> $stable(st_q.row));

    assert_ref_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ref_stb |-> ((st_q.kind == CYC_CBR) || (st_q.kind == CYC_HIDDEN)));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 4,
    parameter int REF_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic               oe_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  dq_in,
    output logic [NUM_CYC-1:0] cyc_type,
    output logic               row_stb,
    output logic               col_stb,
    output logic [ADDR_W-1:0]  row_addr,
    output logic [ADDR_W-1:0]  col_addr,
    output logic               wr_stb,
    output logic [DATA_W-1:0]  wr_data,
    output logic               dq_oe,
    output logic               ref_stb,
    output logic [REF_W-1:0]   ref_row
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [NUM_STB-1:0] stb_raw, stb_lvl, stb_fall;
    logic [BUS_W-1:0]   bus_raw, bus_s;
    strobe_t            lvl, fall;
    cyc_e               kind;

    assign stb_raw = {ras_n, cas_n, we_n, oe_n};
    assign bus_raw = {addr, dq_in};

    dcd_sync #(.WIDTH(NUM_STB), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stb_raw),
        .q     (stb_lvl)
    );

    // Buses ride the same depth so captures line up with the strobe samples.
    dcd_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_s)
    );

    dcd_edge #(.WIDTH(NUM_STB)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (stb_lvl),
        .fall  (stb_fall)
    );

    assign lvl  = strobe_t'(stb_lvl);
    assign fall = strobe_t'(stb_fall);

    dcd_classifier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .fall     (fall),
        .addr_s   (bus_s[BUS_W-1:DATA_W]),
        .din_s    (bus_s[DATA_W-1:0]),
        .kind     (kind),
        .row_stb  (row_stb),
        .col_stb  (col_stb),
        .row_addr (row_addr),
        .col_addr (col_addr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .dq_oe    (dq_oe),
        .ref_stb  (ref_stb)
    );

    dcd_refcnt #(.REF_W(REF_W)) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_stb),
        .cnt   (ref_row)
    );

    assign cyc_type = NUM_CYC'(1) << kind;

    assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cyc_type) == 1);

    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
    localparam int AW = 11;
    localparam int DW = 4;
    localparam int RW = 11;
    localparam int NV = 33;

    typedef struct packed {
        logic [3:0]    ctl;   // {ras_n, cas_n, we_n, oe_n}
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
        logic [3:0]    kind;  // expected one-hot bit index
        logic          oe;    // expected dq_oe
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}, // 0  R1 idle
        '{4'b0111, 11'h155, 4'h0, 4'd7, 1'b0}, // 1  R2 row fall
        '{4'b0011, 11'h2AA, 4'h0, 4'd1, 1'b0}, // 2  R3 col fall, OE high
        '{4'b0010, 11'h2AA, 4'h0, 4'd1, 1'b1}, // 3  R4 OE falls last
        '{4'b0011, 11'h2AA, 4'h0, 4'd1, 1'b0}, // 4  R4 OE high drops drive
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}, // 5  R1 end
        '{4'b0111, 11'h011, 4'h0, 4'd7, 1'b0}, // 6  R2
        '{4'b0101, 11'h011, 4'h0, 4'd7, 1'b0}, // 7  WE low before CAS
        '{4'b0001, 11'h022, 4'h5, 4'd2, 1'b0}, // 8  R5 early write
        '{4'b0000, 11'h022, 4'h5, 4'd2, 1'b0}, // 9  R5 OE low, still off
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}, // 10
        '{4'b0111, 11'h0AB, 4'h0, 4'd7, 1'b0}, // 11
        '{4'b0010, 11'h0CD, 4'h0, 4'd1, 1'b1}, // 12 R4 CAS and OE together
        '{4'b0001, 11'h0CD, 4'h6, 4'd3, 1'b0}, // 13 R7 WE falls, OE rises
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}, // 14
        '{4'b0111, 11'h100, 4'h0, 4'd7, 1'b0}, // 15
        '{4'b0010, 11'h101, 4'h0, 4'd1, 1'b1}, // 16 first column
        '{4'b0110, 11'h101, 4'h0, 4'd1, 1'b1}, // 17 R8 output held, CAS high
        '{4'b0010, 11'h102, 4'h0, 4'd4, 1'b1}, // 18 R8 page read
        '{4'b0110, 11'h102, 4'h0, 4'd4, 1'b1}, // 19 R8
        '{4'b0101, 11'h103, 4'h0, 4'd4, 1'b0}, // 20 WE with CAS high ignored
        '{4'b0001, 11'h103, 4'h9, 4'd5, 1'b0}, // 21 R8 page write
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}, // 22
        '{4'b0111, 11'h200, 4'h0, 4'd7, 1'b0}, // 23
        '{4'b0010, 11'h201, 4'h0, 4'd1, 1'b1}, // 24 read
        '{4'b1010, 11'h201, 4'h0, 4'd1, 1'b1}, // 25 R9 RAS high, CAS held
        '{4'b0010, 11'h201, 4'h0, 4'd6, 1'b1}, // 26 R9 hidden refresh
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}, // 27
        '{4'b1011, 11'h000, 4'h0, 4'd0, 1'b0}, // 28 CAS first
        '{4'b0010, 11'h345, 4'h0, 4'd8, 1'b0}, // 29 R10 CBR, OE low ignored
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}, // 30
        '{4'b0111, 11'h0FF, 4'h0, 4'd7, 1'b0}, // 31 R2 RAS-only refresh
        '{4'b1111, 11'h000, 4'h0, 4'd0, 1'b0}  // 32
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [8:0]    cyc_type;
    logic          row_stb, col_stb, wr_stb, dq_oe, ref_stb;
    logic [AW-1:0] row_addr, col_addr;
    logic [DW-1:0] wr_data;
    logic [RW-1:0] ref_row;

    int n_chk = 0;
    int n_fail = 0;
    int n_row = 0, n_col = 0, n_wr = 0, n_ref = 0;

    always #4 clk = ~clk;

    dram_cycle_decoder u_dut (
        .clk (clk), .rst_n (rst_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .dq_in (dq_in),
        .cyc_type (cyc_type), .row_stb (row_stb), .col_stb (col_stb),
        .row_addr (row_addr), .col_addr (col_addr),
        .wr_stb (wr_stb), .wr_data (wr_data), .dq_oe (dq_oe),
        .ref_stb (ref_stb), .ref_row (ref_row)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (row_stb) n_row++;
            if (col_stb) n_col++;
            if (wr_stb)  n_wr++;
            if (ref_stb) n_ref++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ctl, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        {ras_n, cas_n, we_n, oe_n} = ctl;
        addr  = a;
        dq_in = d;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R13 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 reset cyc_type", 32'(cyc_type), 32'h001);
        chk("R1 reset dq_oe", 32'(dq_oe), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // Table walk: R12 one-hot position, R4 drive state
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ctl, VEC[i].addr, VEC[i].din);
            chk($sformatf("R12 cyc_type vec %0d", i), 32'(cyc_type), 32'(9'd1 << VEC[i].kind));
            chk($sformatf("R4 dq_oe vec %0d", i), 32'(dq_oe), 32'(VEC[i].oe));
        end
        chk("R2 row_stb count", n_row, 6);
        chk("R3 col_stb count", n_col, 7);
        chk("R5 wr_stb count", n_wr, 3);
        chk("R9 ref_stb count", n_ref, 2);
        chk("R11 ref_row after two refreshes", 32'(ref_row), 32'h2);
        chk("R8 wr_data of page write", 32'(wr_data), 32'h9);
        chk("R2 row_addr of RAS-only", 32'(row_addr), 32'h0FF);
        chk("R9 col_addr kept over hidden refresh", 32'(col_addr), 32'h201);

        // R1 reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset cyc_type", 32'(cyc_type), 32'h001);
        chk("R1 reset row_addr", 32'(row_addr), 32'h0);
        chk("R1 reset col_addr", 32'(col_addr), 32'h0);
        chk("R1 reset wr_data", 32'(wr_data), 32'h0);
        chk("R1 reset ref_row", 32'(ref_row), 32'h0);
        chk("R1 reset dq_oe", 32'(dq_oe), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R13 latency: row fall visible on the third rising edge only
        @(negedge clk);
        ras_n = 1'b0;
        addr  = 11'h3FF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R13 no change after two edges", 32'(cyc_type), 32'h001);
        @(posedge clk);
        @(negedge clk);
        chk("R13 change on third edge", 32'(cyc_type), 32'h080);
        chk("R13 row_stb on third edge", 32'(row_stb), 32'h1);
        repeat (3) @(posedge clk);
        chk("R2 row_addr captured", 32'(row_addr), 32'h3FF);

        // R3 column capture, then R6 late write
        drive(4'b0011, 11'h001, 4'h0);
        chk("R3 col_addr captured", 32'(col_addr), 32'h001);
        chk("R3 read class", 32'(cyc_type), 32'h002);
        drive(4'b0001, 11'h001, 4'hA);
        chk("R6 late write class", 32'(cyc_type), 32'h004);
        chk("R6 late write data", 32'(wr_data), 32'hA);
        drive(4'b0001, 11'h001, 4'h3);
        chk("R6 data held after bus change", 32'(wr_data), 32'hA);
        chk("R6 outputs off", 32'(dq_oe), 32'h0);
        drive(4'b1111, 11'h000, 4'h0);

        // R10 CBR ignores the address bus
        drive(4'b1011, 11'h123, 4'h0);
        drive(4'b0011, 11'h123, 4'h0);
        chk("R10 CBR class", 32'(cyc_type), 32'h100);
        chk("R10 row_addr unchanged", 32'(row_addr), 32'h3FF);
        chk("R10 dq_oe off", 32'(dq_oe), 32'h0);
        chk("R11 ref_row stepped", 32'(ref_row), 32'h1);
        drive(4'b1111, 11'h000, 4'h0);

        // R11 wrap after 2048 refreshes in total
        for (int k = 1; k < 2048; k++) begin
            drive(4'b1011, 11'h000, 4'h0);
            drive(4'b0011, 11'h000, 4'h0);
            drive(4'b1111, 11'h000, 4'h0);
        end
        chk("R11 ref_row wrapped", 32'(ref_row), 32'h0);
        chk("R1 standby at end", 32'(cyc_type), 32'h001);

        finish_run();
    end
endmodule